// File: doc/BRIEF.md
# USB Link Activity LED Driver

This block drives an active-low indicator LED for a full-speed USB device controller. Once the host has given the device an address, the LED stays lit. Each acknowledged transaction turns it dark for a fixed blanking window, so traffic shows as a flicker. While the device is suspended, or before it has been addressed, the LED stays dark.

The protocol engine supplies two single-cycle pulses, one for an acknowledged transaction toward the host and one for an acknowledged transaction from the host. It also supplies two level flags: address assigned and suspended. All inputs are plain control pins with no handshake. The blanking window is set by the parameter `BLINK_CYCLES`, counted in clock cycles. The default gives 100 ms at 48 MHz, and a bench can pick a short value.

Top module: `usb_link_led`

## Requirements
- R1: While reset is held, the blanking timer is cleared. In the first cycle after reset is released, with the address flag high, the suspend flag low and no pulses, `led_n_o` is 0 (lit).
- R2: While `addr_set_i` is 0, `led_n_o` is 1 (dark) whatever pulses arrive. Pulses seen while unaddressed are discarded, so the LED lights in the same cycle the flag rises.
- R3: While the device is addressed, not suspended and sees no pulses, `led_n_o` stays 0 for any number of cycles.
- R4: A pulse on `ack_in_i` that is sampled at a rising clock edge while the device is addressed and not suspended sets `led_n_o` to 1 for exactly `BLINK_CYCLES` cycles. The window starts right after that edge. Afterwards `led_n_o` returns to 0.
- R5: A pulse on `ack_out_i` under the same conditions produces the same blanking window as R4.
- R6: Pulses on both acknowledge inputs in the same cycle produce one window of `BLINK_CYCLES` cycles.
- R7: A pulse that arrives while a window is running restarts the full `BLINK_CYCLES` window from that edge.
- R8: While `suspend_i` is 1, `led_n_o` is 1. A clock edge that samples suspend high aborts any window in progress, and pulses sampled during suspend are discarded, so the LED lights in the first cycle after suspend falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_set_i | input | 1 | Level: device address has been assigned |
| suspend_i | input | 1 | Level: bus is in the suspended state |
| ack_in_i | input | 1 | One-cycle pulse: acknowledged transaction toward the host |
| ack_out_i | input | 1 | One-cycle pulse: acknowledged transaction from the host |
| led_n_o | output | 1 | LED drive, 0 = lit |

## Verification
The bench sends a second pulse at every offset from one cycle after the first pulse up to one cycle past the end of the window.
- If the timer did not restart, the window would end early.
- If the timer added the new pulse to the time left, the window would run long.
- An off-by-one error in the counter shows up as a window one cycle too short or too long, on either pulse input or on both inputs together.

Suspend is raised in the middle of a window and pulses are sent during suspend. If the abort were missing, or pulses were latched during suspend, the LED would stay dark after suspend falls. The same test, run with the address flag low, catches any pulse that is remembered before addressing.

// File: rtl/usb_link_led_pkg.sv
package usb_link_led_pkg;

  // Counter width able to hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  typedef enum logic [0:0] {
    ACK_TO_HOST   = 1'b0,
    ACK_FROM_HOST = 1'b1
  } ack_dir_e;

endpackage

// File: rtl/usb_link_led_ack_merge.sv
module usb_link_led_ack_merge #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] ack_vec_i,
  input  logic               enable_i,
  output logic               trig_o
);

  logic [NUM_SRC:0] chain;

  assign chain[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_or
    assign chain[g+1] = chain[g] | ack_vec_i[g];
  end

  assign trig_o = enable_i & chain[NUM_SRC];

endmodule

// File: rtl/usb_link_led_blank_timer.sv
module usb_link_led_blank_timer #(
  parameter int unsigned BLINK_CYCLES = 4_800_000,
  parameter int unsigned CNT_W        = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic load_i,
  output logic blanking_o
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BLINK_CYCLES);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (clear_i) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= LOAD_VAL;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - ONE;
    end
  end

  assign blanking_o = (remain_q != '0);

  AST_CLEAR_ENDS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !blanking_o) else $error("clear did not end blanking"); // R8

  AST_LOAD_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clear_i) |=> (remain_q == LOAD_VAL)) else $error("load not full"); // R7

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !load_i && blanking_o) |=> (remain_q == $past(remain_q) - ONE))
    else $error("count did not step down"); // R4

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    remain_q <= LOAD_VAL) else $error("count above window"); // R4

endmodule

// File: rtl/usb_link_led.sv
module usb_link_led #(
  parameter int unsigned BLINK_CYCLES = 4_800_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_set_i,
  input  logic suspend_i,
  input  logic ack_in_i,
  input  logic ack_out_i,
  output logic led_n_o
);

  import usb_link_led_pkg::*;

  localparam int unsigned CNT_W   = cnt_width(BLINK_CYCLES);
  localparam int unsigned NUM_SRC = 2;

  logic               link_live;
  logic [NUM_SRC-1:0] ack_vec;
  logic               trig;
  logic               blanking;

  assign link_live = addr_set_i & ~suspend_i;

  assign ack_vec[ACK_TO_HOST]   = ack_in_i;
  assign ack_vec[ACK_FROM_HOST] = ack_out_i;

  usb_link_led_ack_merge #(
    .NUM_SRC (NUM_SRC)
  ) u_merge (
    .ack_vec_i (ack_vec),
    .enable_i  (link_live),
    .trig_o    (trig)
  );

  usb_link_led_blank_timer #(
    .BLINK_CYCLES (BLINK_CYCLES),
    .CNT_W        (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (~link_live),
    .load_i     (trig),
    .blanking_o (blanking)
  );

  assign led_n_o = ~(link_live & ~blanking);

  AST_DARK_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> led_n_o) else $error("LED lit right after ack"); // R4

  AST_DARK_UNADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_set_i && (ack_in_i || ack_out_i)) |=> !blanking)
    else $error("pulse latched while unaddressed"); // R2

endmodule

// File: tb/usb_link_led_tb.sv
module usb_link_led_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_set = 1'b0;
  logic suspend = 1'b0;
  logic ack_in = 1'b0;
  logic ack_out = 1'b0;
  logic led_n;

  int checks = 0;
  int failures = 0;
  int edge_idx = 0;
  int last_pulse = -1000;
  int last_kill = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_link_led #(.BLINK_CYCLES(N)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_set_i (addr_set),
    .suspend_i  (suspend),
    .ack_in_i   (ack_in),
    .ack_out_i  (ack_out),
    .led_n_o    (led_n)
  );

  task automatic check(input string tag, input logic exp);
    checks++;
    if (led_n !== exp) begin
      failures++;
      $display("FAIL %s cycle %0d: led_n=%b expected %b", tag, edge_idx, led_n, exp);
    end
  endtask

  // One clock: drive at negedge, model the edge arithmetically, check after it.
  task automatic cyc(input string tag, input logic a, input logic s,
                     input logic ai, input logic ao);
    logic exp;
    @(negedge clk);
    addr_set = a; suspend = s; ack_in = ai; ack_out = ao;
    @(posedge clk);
    edge_idx++;
    if (!a || s) last_kill = edge_idx;
    else if (ai || ao) last_pulse = edge_idx;
    #1;
    exp = (!a || s) ? 1'b1 :
          ((last_pulse > last_kill) && (edge_idx - last_pulse < N)) ? 1'b1 : 1'b0;
    check(tag, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    addr_set = 1'b1;
    repeat (3) begin
      @(posedge clk);
      edge_idx++;
      last_kill = edge_idx;
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", 1'b0);
    cyc("R1", 1, 0, 0, 0);

    // R2: unaddressed pulses ignored
    for (int k = 0; k < 8; k++) cyc("R2", 0, 0, k[0], k[1]);
    cyc("R2", 1, 0, 0, 0);

    // R3: steady on
    for (int k = 0; k < 20; k++) cyc("R3", 1, 0, 0, 0);

    // R4, R5, R6: single blinks on each source mix
    for (int src = 1; src < 4; src++) begin
      string t;
      t = (src == 1) ? "R4" : (src == 2) ? "R5" : "R6";
      cyc(t, 1, 0, src[0], src[1]);
      for (int k = 0; k < N + 3; k++) cyc(t, 1, 0, 0, 0);
    end

    // R7: retrigger at every offset
    for (int d = 1; d <= N + 1; d++) begin
      cyc("R7", 1, 0, 1, 0);
      for (int k = 1; k < d; k++) cyc("R7", 1, 0, 0, 0);
      cyc("R7", 1, 0, 0, 1);
      for (int k = 0; k < N + 2; k++) cyc("R7", 1, 0, 0, 0);
    end

    // R8: suspend aborts and blocks pulses
    for (int d = 0; d < N; d++) begin
      cyc("R8", 1, 0, 1, 1);
      for (int k = 0; k < d; k++) cyc("R8", 1, 0, 0, 0);
      cyc("R8", 1, 1, 0, 0);
      cyc("R8", 1, 1, 1, 0);
      cyc("R8", 1, 1, 0, 1);
      cyc("R8", 1, 0, 0, 0);
      cyc("R8", 1, 0, 0, 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule